// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Port with Periodic Interrupt

This block is the register side of a real-time-clock device, reached through two byte ports that share one data bus. A write to the index port picks one of fourteen locations. Accesses to the data port then reach the location picked. Locations 0 to 9 are plain bytes that hold the time and date fields. They are loaded at reset from calendar parameters and are never advanced by the block itself. Location 0xA is status/control register A and location 0xB is control register B. Locations 0xC and 0xD are status registers that always read as zero.

Only one configuration of registers A and B is supported. A write that asks for anything else is refused: it raises a one-cycle error pulse and leaves the register unchanged. Each read of register A flips its update-in-progress flag, so software that polls the flag sees it move.

The periodic-enable bit of register B gates a free-running generator. While the bit is set, the generator emits a one-cycle interrupt pulse every `PERIOD_CYCLES` clock cycles.

Top module: `rtc_index_port`

## Requirements
- R1: After reset: the index is 0, register A is 0x26 (bits 6:4 = 010 for the 32.768 kHz base, bits 3:0 = 0110 for the 1024 Hz rate), register B is 0x46, and `irq` and `err` are low.
- R2: Index-port writes (`sel`=0) of values up to 0x0D set the index. Larger values set `err` high for the cycle after the write and leave the index unchanged. An index-port read (`sel`=0, `rd_en`) returns the index in bits 3:0 and zeros above.
- R3: Data-port reads and writes (`sel`=1) at indices 0 to 9 reach ten independent byte registers. Read data appears on `rdata` the cycle after `rd_en` and holds until the next read.
- R4: Each data-port read of register A inverts bit 7 (update-in-progress) first, then returns the new value. The first read after reset returns 0xA6 and the second returns 0x26.
- R5: A write to register A is accepted only if it is exactly 0x26. Any other value sets `err` and leaves A unchanged.
- R6: A write to register B is accepted only if the value, with bit 6 (periodic enable) and bit 3 (square-wave enable) masked off, equals 0x06 (bit 2 binary mode, bit 1 24-hour mode). A refused write sets `err` and leaves B unchanged.
- R7: Registers 0xC and 0xD read as 0x00, and any write to them sets `err`.
- R8: While periodic enable is set, `irq` is high for one cycle every `PERIOD_CYCLES` cycles. The generator is armed at reset, so the first pulse comes `PERIOD_CYCLES` cycles after reset release.
- R9: Clearing periodic enable stops the pulses at once. Setting it while cleared restarts a full interval, counted from the write cycle. Writing it set while already set does not disturb the running interval.
- R10: At reset the clock bytes are loaded from calendar parameters. Location 0 holds seconds, 2 minutes, 4 hours, 6 the weekday (0-based parameter plus 1), 7 the day of month, 8 the month (0-based parameter plus 1) and 9 the year minus 1900. Locations 1, 3 and 5 hold 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Port select: 0 index port, 1 data port |
| wr_en | input | 1 | Write strobe; takes precedence over `rd_en` |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| err | output | 1 | One-cycle pulse after a refused write |
| irq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
The hardest cases to reach from the ports are the transitions of the periodic generator. These are a restart after it has been disabled, and a re-write of the enable bit while it is running, which must not move the phase.

The stimulus disables the generator and watches a window three intervals long in which no pulse may appear. It then re-enables the generator and times the first pulse from the write cycle. Next it writes register B with the enable already set, and times the following pulses.

A behavioural model in the bench follows every clock. Any shift in phase therefore shows up at once as an `irq` mismatch.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned NUM_CLK  = 10;
  localparam logic [IDX_W-1:0] IDX_MAX = 4'hD;
  localparam logic [IDX_W-1:0] LOC_A   = 4'hA;
  localparam logic [IDX_W-1:0] LOC_B   = 4'hB;
  localparam logic [IDX_W-1:0] LOC_C   = 4'hC;
  localparam logic [IDX_W-1:0] LOC_D   = 4'hD;

  localparam int unsigned UIP_BIT = 7;
  localparam int unsigned PIE_BIT = 6;
  localparam int unsigned SQW_BIT = 3;

  localparam logic [BYTE_W-1:0] A_CFG       = 8'h26;
  localparam logic [BYTE_W-1:0] B_FREE_MASK = (8'h1 << PIE_BIT) | (8'h1 << SQW_BIT);
  localparam logic [BYTE_W-1:0] B_CFG       = 8'h06;
  localparam logic [BYTE_W-1:0] B_RST       = B_CFG | (8'h1 << PIE_BIT);

  // Reset value of one clock byte, derived from a calendar time.
  function automatic logic [BYTE_W-1:0] calendar_byte(
      input int unsigned loc, input int unsigned sec, input int unsigned min,
      input int unsigned hour, input int unsigned wday0, input int unsigned mday,
      input int unsigned mon0, input int unsigned year);
    int unsigned v;
    case (loc)
      0:       v = sec;
      2:       v = min;
      4:       v = hour;
      6:       v = wday0 + 1;
      7:       v = mday;
      8:       v = mon0 + 1;
      9:       v = year - 1900;
      default: v = 0;
    endcase
    return v[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/rtc_index_sel.sv
module rtc_index_sel
  import rtc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              bad_o
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             in_range;
  logic             load_en;

  assign in_range = (wdata_i <= BYTE_W'(IDX_MAX));
  assign load_en  = wr_i & in_range;
  assign bad_o    = wr_i & ~in_range;

  always_comb begin
    idx_d = idx_q;
    if (load_en) idx_d = wdata_i[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (load_en) idx_q <= idx_d;
  end

  assign idx_o = idx_q;

  // R2
  bad_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_o |=> (idx_q == $past(idx_q)));
endmodule

// File: rtl/rtc_status_ab.sv
module rtc_status_ab
  import rtc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] a_o,
  output logic [BYTE_W-1:0] b_o,
  output logic              pie_cur_o,
  output logic              pie_next_o,
  output logic              bad_o
);
  logic [BYTE_W-1:0] a_q, a_d, b_q, b_d;
  logic              a_en, b_en;

  always_comb begin
    a_d   = a_q;
    b_d   = b_q;
    bad_o = 1'b0;
    if (wr_i) begin
      case (idx_i)
        LOC_A: if (wdata_i == A_CFG) a_d = wdata_i; else bad_o = 1'b1;
        LOC_B: if ((wdata_i & ~B_FREE_MASK) == B_CFG) b_d = wdata_i; else bad_o = 1'b1;
        LOC_C, LOC_D: bad_o = 1'b1;
        default: ;
      endcase
    end else if (rd_i && idx_i == LOC_A) begin
      a_d[UIP_BIT] = ~a_q[UIP_BIT];
    end
  end

  assign a_en = (wr_i | rd_i) & (idx_i == LOC_A);
  assign b_en = wr_i & (idx_i == LOC_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= A_CFG;
      b_q <= B_RST;
    end else begin
      if (a_en) a_q <= a_d;
      if (b_en) b_q <= b_d;
    end
  end

  assign a_o        = a_q;
  assign b_o        = b_q;
  assign pie_cur_o  = b_q[PIE_BIT];
  assign pie_next_o = b_d[PIE_BIT];

  // R5
  a_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_q & 8'h7F) == A_CFG);
  // R6
  b_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_q & ~B_FREE_MASK) == B_CFG);
  // R4
  uip_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !wr_i && idx_i == LOC_A) |=> (a_q[UIP_BIT] != $past(a_q[UIP_BIT])));
endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen #(
  parameter int unsigned PERIOD_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_cur_i,
  input  logic en_next_i,
  output logic irq_o
);
  localparam int unsigned CNT_W = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    irq_d = 1'b0;
    if (!en_next_i) begin
      cnt_d = cnt_q;
    end else if (!en_cur_i) begin
      cnt_d = RELOAD;
    end else if (cnt_q == '0) begin
      irq_d = 1'b1;
      cnt_d = RELOAD;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign cnt_en = en_next_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
      irq_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R8
  irq_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> en_cur_i);
  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_cur_i |=> !irq_q);
endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port
  import rtc_regs_pkg::*;
#(
  parameter int unsigned PERIOD_CYCLES = 40,
  parameter int unsigned INIT_SEC      = 30,
  parameter int unsigned INIT_MIN      = 15,
  parameter int unsigned INIT_HOUR     = 9,
  parameter int unsigned INIT_WDAY0    = 3,
  parameter int unsigned INIT_MDAY     = 14,
  parameter int unsigned INIT_MON0     = 5,
  parameter int unsigned INIT_YEAR     = 2004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              err,
  output logic              irq
);
  logic              wr_idx, wr_dat, rd_idx, rd_dat;
  logic [IDX_W-1:0]  idx;
  logic              bad_idx, bad_stat;
  logic [BYTE_W-1:0] reg_a, reg_b;
  logic              pie_cur, pie_next;
  logic [BYTE_W-1:0] clk_byte [NUM_CLK];
  logic [BYTE_W-1:0] clk_rd;
  logic [BYTE_W-1:0] rdata_q, rdata_d;
  logic              rd_any;
  logic              err_q;

  assign wr_idx = wr_en & ~sel;
  assign wr_dat = wr_en &  sel;
  assign rd_idx = rd_en & ~wr_en & ~sel;
  assign rd_dat = rd_en & ~wr_en &  sel;
  assign rd_any = rd_idx | rd_dat;

  rtc_index_sel u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_idx),
    .wdata_i (wdata),
    .idx_o   (idx),
    .bad_o   (bad_idx)
  );

  rtc_status_ab u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_dat),
    .rd_i       (rd_dat),
    .idx_i      (idx),
    .wdata_i    (wdata),
    .a_o        (reg_a),
    .b_o        (reg_b),
    .pie_cur_o  (pie_cur),
    .pie_next_o (pie_next),
    .bad_o      (bad_stat)
  );

  rtc_periodic_gen #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_cur_i  (pie_cur),
    .en_next_i (pie_next),
    .irq_o     (irq)
  );

  for (genvar gi = 0; gi < NUM_CLK; gi++) begin : g_clk
    localparam logic [BYTE_W-1:0] RST_VAL = calendar_byte(gi, INIT_SEC, INIT_MIN,
      INIT_HOUR, INIT_WDAY0, INIT_MDAY, INIT_MON0, INIT_YEAR);
    logic byte_en;
    assign byte_en = wr_dat & (idx == IDX_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       clk_byte[gi] <= RST_VAL;
      else if (byte_en) clk_byte[gi] <= wdata;
    end
  end

  always_comb begin
    clk_rd = '0;
    for (int i = 0; i < NUM_CLK; i++) begin
      if (idx == IDX_W'(i)) clk_rd = clk_byte[i];
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_idx) begin
      rdata_d = BYTE_W'(idx);
    end else if (rd_dat) begin
      if (idx < IDX_W'(NUM_CLK))  rdata_d = clk_rd;
      else if (idx == LOC_A)      rdata_d = {~reg_a[UIP_BIT], reg_a[UIP_BIT-1:0]};
      else if (idx == LOC_B)      rdata_d = reg_b;
      else                        rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (rd_any) rdata_q <= rdata_d;
      err_q <= bad_idx | bad_stat;
    end
  end

  assign rdata = rdata_q;
  assign err   = err_q;

  // R7
  cd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat && (idx == LOC_C || idx == LOC_D)) |=> (rdata_q == '0));
  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_MAX);
endmodule

// File: tb/sim_rtc_index_port.sv
module sim_rtc_index_port;
  localparam int P = 40;

  logic       clk, rst_n, sel, wr_en, rd_en;
  logic [7:0] wdata, rdata;
  logic       err, irq;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // behavioural reference state
  int m_idx, m_a, m_b, m_rdata, m_err, m_irq, m_cnt;
  int m_mem [10];

  rtc_index_port #(.PERIOD_CYCLES(P)) u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .err(err), .irq(irq));

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic model_reset();
    m_idx = 0; m_a = 'h26; m_b = 'h46; m_rdata = 0; m_err = 0; m_irq = 0; m_cnt = P - 1;
    m_mem = '{30, 0, 15, 0, 9, 0, 4, 14, 6, 104};
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) model_reset();
    else begin
      int old_en, new_en;
      old_en = (m_b >> 6) & 1;
      m_err = 0;
      if (wr_en) begin
        if (!sel) begin
          if (wdata <= 13) m_idx = wdata; else m_err = 1;
        end else if (m_idx < 10) m_mem[m_idx] = wdata;
        else if (m_idx == 10) begin if (wdata == 8'h26) m_a = wdata; else m_err = 1; end
        else if (m_idx == 11) begin if ((wdata & 8'hB7) == 8'h06) m_b = wdata; else m_err = 1; end
        else m_err = 1;
      end else if (rd_en) begin
        if (!sel) m_rdata = m_idx;
        else if (m_idx < 10) m_rdata = m_mem[m_idx];
        else if (m_idx == 10) begin m_a = m_a ^ 'h80; m_rdata = m_a; end
        else if (m_idx == 11) m_rdata = m_b;
        else m_rdata = 0;
      end
      new_en = (m_b >> 6) & 1;
      m_irq = 0;
      if (new_en == 1) begin
        if (old_en == 0) m_cnt = P - 1;
        else if (m_cnt == 0) begin m_irq = 1; m_cnt = P - 1; end
        else m_cnt--;
      end
    end
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && cyc > 0 && !done) begin
      chk("R3 model rdata", rdata, m_rdata);
      chk("R2 model err", err, m_err);
      chk("R8 model irq", irq, m_irq);
    end
  end

  task automatic wr(bit s, logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(bit s);
    @(negedge clk); sel = s; rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  initial begin
    int n;
    model_reset();
    rst_n = 0; sel = 0; wr_en = 0; rd_en = 0; wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1 irq reset", irq, 0);
    chk("R1 err reset", err, 0);
    rst_n = 1;
    n = 0;
    while (!irq && n < 1000) begin @(negedge clk); n++; end
    chk("R8 first pulse delay", n, P);

    rd(0);               chk("R1 index reset", rdata, 0);
    wr(0, 8'h0A); rd(1); chk("R4 first A read", rdata, 'hA6);
    rd(1);               chk("R4 second A read", rdata, 'h26);
    wr(0, 8'h0B); rd(1); chk("R1 B reset", rdata, 'h46);

    wr(0, 0); rd(1); chk("R10 seconds", rdata, 30);
    wr(0, 1); rd(1); chk("R10 alarm zero", rdata, 0);
    wr(0, 6); rd(1); chk("R10 weekday", rdata, 4);
    wr(0, 8); rd(1); chk("R10 month", rdata, 6);
    wr(0, 9); rd(1); chk("R10 year", rdata, 104);

    wr(0, 2); wr(1, 8'h5A); rd(1); chk("R3 byte 2", rdata, 'h5A);
    wr(0, 9); wr(1, 8'hC3); rd(1); chk("R3 byte 9", rdata, 'hC3);
    wr(0, 2); rd(1); chk("R3 byte 2 kept", rdata, 'h5A);

    wr(0, 9);
    wr(0, 8'h0E); chk("R2 err on 0x0E", err, 1);
    rd(0);        chk("R2 index held", rdata, 9);
    wr(0, 8'hFF); chk("R2 err on 0xFF", err, 1);
    wr(0, 8'h0D); chk("R2 0x0D accepted", err, 0);
    rd(0);        chk("R2 index 0x0D", rdata, 13);

    wr(0, 8'h0A);
    wr(1, 8'h27); chk("R5 bad A write err", err, 1);
    wr(1, 8'hA6); chk("R5 A with UIP err", err, 1);
    wr(1, 8'h26); chk("R5 good A write", err, 0);
    rd(1);        chk("R5 A value", rdata, 'hA6);

    wr(0, 8'h0B);
    wr(1, 8'h47); chk("R6 bad B write err", err, 1);
    rd(1);        chk("R6 B unchanged", rdata, 'h46);
    wr(1, 8'h4E); chk("R6 B with square wave", err, 0);
    rd(1);        chk("R6 B readback", rdata, 'h4E);

    wr(0, 8'h0C); rd(1); chk("R7 C reads zero", rdata, 0);
    wr(1, 8'h00); chk("R7 C write err", err, 1);
    wr(0, 8'h0D); rd(1); chk("R7 D reads zero", rdata, 0);
    wr(1, 8'h11); chk("R7 D write err", err, 1);

    wr(0, 8'h0B);
    wr(1, 8'h06);
    n = 0;
    for (int i = 0; i < 3 * P; i++) begin @(negedge clk); if (irq) n++; end
    chk("R9 no pulses when disabled", n, 0);
    wr(1, 8'h46);
    n = 0;
    while (!irq && n < 1000) begin @(negedge clk); n++; end
    chk("R9 restart delay", n, P);
    repeat (5) @(negedge clk);
    wr(1, 8'h4E);
    n = 0;
    while (!irq && n < 1000) begin @(negedge clk); n++; end
    n = 0;
    @(negedge clk); n++;
    while (!irq && n < 1000) begin @(negedge clk); n++; end
    chk("R8 interval", n, P);
    repeat (2 * P) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule